// File: doc/BRIEF.md
# Dual-Channel Prescaled Interval Timer

This block is a small timer peripheral with two independent 16-bit up-counters that are clocked from one shared functional clock. Each channel passes that clock through its own power-of-two divider, so the two channels can count at different rates. A channel counts up to a programmed limit and then raises a sticky pending flag. It then either wraps to zero and continues, or stops and holds its value. Software starts a new interval by clearing the enable bit, writing the limit and then setting enable again. With the limit at 0xFFFF and wrap mode selected, the counter runs freely and serves as a continuous time base.

Access uses a plain 16-bit register port with an address, a write strobe, write data and combinational read data. Each channel has a bank of four registers: control, status, limit and count. Channel `n` occupies the bank that starts at byte offset `(n+1)*0x80`. Each channel drives its own interrupt line.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset every register of both channels reads 0 and both interrupt lines are low.
- R2: Channel n's bank starts at (n+1)*0x80. Inside a bank, control is at +0x0, status at +0x4, limit at +0x8 and count at +0xC. Control holds the interrupt enable (bit 8), the run enable (bit 5), the one-shot select (bit 4) and the divider code (bits 3:0). All other control bits read 0. The limit register reads back what was last written.
- R3: While enabled, the counter advances once every 2^c functional clocks, where c is the divider code. Codes above 8 act as 8. A channel enabled at edge 0 shows floor(k/2^c) on its count after edge k.
- R4: Writing the run enable from 0 to 1 clears the counter and the divider. Writing it as 1 while the channel already runs restarts nothing.
- R5: In wrap mode (bit 4 = 0), an advance that finds the count equal to the limit sets the pending flag and returns the count to 0. With a limit of 0xFFFF the counter runs through all values and wraps.
- R6: In one-shot mode (bit 4 = 1), that terminal advance sets the pending flag, clears the run enable in hardware and leaves the count holding the limit value.
- R7: Status bit 0 is the pending flag. Writing 1 to bit 0 clears it and writing 0 leaves it unchanged. A terminal advance in the same cycle as a clear leaves the flag set.
- R8: A channel's interrupt line equals its pending flag ANDed with its interrupt enable bit.
- R9: While the run enable is 0 the count does not change, and clearing the run enable leaves the pending flag unchanged.
- R10: The two channels run independently, each with its own divider code, limit and start time.
- R11: Reads from unmapped offsets (bank 0, banks above the last channel, or any offset other than 0x0/0x4/0x8/0xC inside a bank) return 0. Writes there change nothing. Writes to the count register are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock shared by both channels |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 10 | Byte address of the register access |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr`, combinational |
| irq | output | 2 | Per-channel interrupt, bit n for channel n |

## Verification
The bench sweeps every divider code, including one above 8, and checks the count after a fixed number of cycles against floor(k/2^c). A design with an off-by-one divider, or one that misses the clip at 8, reports a wrong count. For a grid of small limits and codes, the bench checks that the flag is still clear one cycle before the terminal advance and set exactly on it. A design that compares against limit-1, or that reloads to 1 instead of 0, fails at those edges. Further tests cover one-shot stop-and-hold, a full 16-bit wrap, a rewrite of the enable bit that must not restart the count, write-zero and write-one to the status flag, and a staggered start of both channels. Other tests write unmapped addresses and the count register, which would corrupt state in a design with a loose decode.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int DATA_W = 16;
  localparam int CODE_W = 4;
  localparam int IE_BIT = 8;
  localparam int EN_BIT = 5;
  localparam int OS_BIT = 4;
  localparam int OFS_CTRL = 'h0;
  localparam int OFS_STAT = 'h4;
  localparam int OFS_LOAD = 'h8;
  localparam int OFS_CNT  = 'hC;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_STAT, SEL_LOAD, SEL_CNT
  } reg_sel_e;

  typedef struct packed {
    logic              ie;
    logic              en;
    logic              os;
    logic [CODE_W-1:0] code;
  } ctrl_t;
endpackage

// File: rtl/ivt_rst_sync.sv
module ivt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/ivt_decode.sv
module ivt_decode
  import ivt_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int ADDR_W    = 10,
  parameter int STRIDE_LG = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NCH-1:0]    ch_hit,
  output reg_sel_e          sel
);
  localparam int BANK_W = ADDR_W - STRIDE_LG;

  logic [BANK_W-1:0]    bank;
  logic [STRIDE_LG-1:0] offs;

  assign bank = addr[ADDR_W-1:STRIDE_LG];
  assign offs = addr[STRIDE_LG-1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_hit
    assign ch_hit[g] = (bank == BANK_W'(g + 1));
  end

  always_comb begin
    sel = SEL_NONE;
    if (ch_hit != '0) begin
      if      (offs == STRIDE_LG'(OFS_CTRL)) sel = SEL_CTRL;
      else if (offs == STRIDE_LG'(OFS_STAT)) sel = SEL_STAT;
      else if (offs == STRIDE_LG'(OFS_LOAD)) sel = SEL_LOAD;
      else if (offs == STRIDE_LG'(OFS_CNT))  sel = SEL_CNT;
    end
  end
endmodule

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
  parameter int CODE_W  = 4,
  parameter int PSC_MAX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int PSC_W = PSC_MAX;

  logic [PSC_W-1:0]  div_q, div_d, mask;
  logic [CODE_W-1:0] eff;
  logic              div_ce;

  always_comb begin
    eff = (code > CODE_W'(PSC_MAX)) ? CODE_W'(PSC_MAX) : code;
    mask = '0;
    for (int b = 0; b < PSC_W; b++) mask[b] = (b < int'(eff));
  end

  assign tick   = run & (&(div_q | ~mask));
  assign div_ce = restart | run;

  always_comb begin
    if (restart) div_d = '0;
    else         div_d = div_q + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_ce) div_q <= div_d;
  end
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PSC_MAX = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  ctrl_t            ctrl_wdat,
  input  logic             stat_we,
  input  logic             clr_bit,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_wdat,
  output ctrl_t            ctrl_q,
  output logic             pend_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] load_q
);
  ctrl_t            ctrl_d;
  logic             pend_d;
  logic [CNT_W-1:0] cnt_d;
  logic             tick, term, restart;
  logic             ctrl_ce, cnt_ce;

  assign restart = ctrl_we & ctrl_wdat.en & ~ctrl_q.en;

  ivt_prescaler #(.CODE_W(CODE_W), .PSC_MAX(PSC_MAX)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.en),
    .restart (restart),
    .code    (ctrl_q.code),
    .tick    (tick)
  );

  assign term = tick & (cnt_q == load_q);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we)             ctrl_d = ctrl_wdat;
    else if (term && ctrl_q.os) ctrl_d.en = 1'b0;
  end
  assign ctrl_ce = ctrl_we | (term & ctrl_q.os);

  always_comb begin
    if (restart)     cnt_d = '0;
    else if (term)   cnt_d = ctrl_q.os ? cnt_q : '0;
    else             cnt_d = cnt_q + CNT_W'(1);
  end
  assign cnt_ce = restart | tick;

  assign pend_d = term | (pend_q & ~(stat_we & clr_bit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      load_q <= '0;
    end else begin
      if (ctrl_ce) ctrl_q <= ctrl_d;
      pend_q <= pend_d;
      if (cnt_ce)  cnt_q  <= cnt_d;
      if (load_we) load_q <= load_wdat;
    end
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import ivt_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int ADDR_W    = 10,
  parameter int STRIDE_LG = 7,
  parameter int PSC_MAX   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  output logic [NCH-1:0]    irq
);
  localparam int CNT_W = DATA_W;

  logic                       rst_n_i;
  logic [NCH-1:0]             ch_hit;
  reg_sel_e                   sel;
  ctrl_t                      ctrl_wdat;
  logic [NCH-1:0]             en_v, ie_v, pend_v;
  logic [NCH-1:0][CNT_W-1:0]  cnt_v;
  logic [NCH-1:0][DATA_W-1:0] rd_word;

  ivt_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  ivt_decode #(.NCH(NCH), .ADDR_W(ADDR_W), .STRIDE_LG(STRIDE_LG)) u_dec (
    .addr(addr), .ch_hit(ch_hit), .sel(sel)
  );

  assign ctrl_wdat.ie   = wr_data[IE_BIT];
  assign ctrl_wdat.en   = wr_data[EN_BIT];
  assign ctrl_wdat.os   = wr_data[OS_BIT];
  assign ctrl_wdat.code = wr_data[CODE_W-1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] load_q;
    logic             wr_hit;

    assign wr_hit = wr_en & ch_hit[g];

    ivt_channel #(.CNT_W(CNT_W), .PSC_MAX(PSC_MAX)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n_i),
      .ctrl_we   (wr_hit & (sel == SEL_CTRL)),
      .ctrl_wdat (ctrl_wdat),
      .stat_we   (wr_hit & (sel == SEL_STAT)),
      .clr_bit   (wr_data[0]),
      .load_we   (wr_hit & (sel == SEL_LOAD)),
      .load_wdat (wr_data),
      .ctrl_q    (ctrl_q),
      .pend_q    (pend_v[g]),
      .cnt_q     (cnt_v[g]),
      .load_q    (load_q)
    );

    assign en_v[g] = ctrl_q.en;
    assign ie_v[g] = ctrl_q.ie;
    assign irq[g]  = pend_v[g] & ctrl_q.ie;

    always_comb begin
      rd_word[g] = '0;
      case (sel)
        SEL_CTRL: begin
          rd_word[g][IE_BIT]       = ctrl_q.ie;
          rd_word[g][EN_BIT]       = ctrl_q.en;
          rd_word[g][OS_BIT]       = ctrl_q.os;
          rd_word[g][CODE_W-1:0]   = ctrl_q.code;
        end
        SEL_STAT: rd_word[g][0] = pend_v[g];
        SEL_LOAD: rd_word[g]    = load_q;
        SEL_CNT:  rd_word[g]    = cnt_v[g];
        default:  rd_word[g]    = '0;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_hit[i]) rd_data = rd_data | rd_word[i];
    end
  end
endmodule

// File: rtl/ivt_checker.sv
module ivt_checker #(
  parameter int NCH       = 2,
  parameter int ADDR_W    = 10,
  parameter int STRIDE_LG = 7,
  parameter int CNT_W     = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ADDR_W-1:0]         addr,
  input logic                      wr_en,
  input logic                      clr_bit,
  input logic [15:0]               rd_data,
  input logic [NCH-1:0]            irq,
  input logic [NCH-1:0]            en_v,
  input logic [NCH-1:0]            ie_v,
  input logic [NCH-1:0]            pend_v,
  input logic [NCH-1:0][CNT_W-1:0] cnt_v
);
  localparam int BANK_W = ADDR_W - STRIDE_LG;

  logic [BANK_W-1:0]    bank;
  logic [STRIDE_LG-1:0] offs;
  logic                 bank_ok, offs_ok;

  assign bank    = addr[ADDR_W-1:STRIDE_LG];
  assign offs    = addr[STRIDE_LG-1:0];
  assign bank_ok = (bank != '0) && (int'(bank) <= NCH);
  assign offs_ok = (offs == STRIDE_LG'('h0)) || (offs == STRIDE_LG'('h4)) ||
                   (offs == STRIDE_LG'('h8)) || (offs == STRIDE_LG'('hC));

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(bank_ok && offs_ok) |-> rd_data == 16'h0000); // R11

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    logic ctrl_wr, stat_clr;
    assign ctrl_wr  = wr_en && (bank == BANK_W'(g + 1)) && (offs == STRIDE_LG'('h0));
    assign stat_clr = wr_en && (bank == BANK_W'(g + 1)) && (offs == STRIDE_LG'('h4)) && clr_bit;

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_v[g] && !ctrl_wr) |=> $stable(cnt_v[g])); // R9

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      en_v[g] |=> (cnt_v[g] == $past(cnt_v[g]) ||
                   cnt_v[g] == CNT_W'($past(cnt_v[g]) + 1) ||
                   cnt_v[g] == '0)); // R3

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_v[g] && !stat_clr) |=> pend_v[g]); // R7

    AST_STOP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (en_v[g] && !ctrl_wr) |=> (en_v[g] || pend_v[g])); // R6

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[g]) |-> ($rose(pend_v[g]) || $rose(ie_v[g]))); // R8
  end
endmodule

bind dual_interval_timer ivt_checker #(
  .NCH(NCH), .ADDR_W(ADDR_W), .STRIDE_LG(STRIDE_LG), .CNT_W(CNT_W)
) u_ivt_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .wr_en   (wr_en),
  .clr_bit (wr_data[0]),
  .rd_data (rd_data),
  .irq     (irq),
  .en_v    (en_v),
  .ie_v    (ie_v),
  .pend_v  (pend_v),
  .cnt_v   (cnt_v)
);

// File: tb/dual_interval_timer_bench.sv
`timescale 1ns/1ps
module dual_interval_timer_bench;
  localparam logic [15:0] B_IE = 16'h0100;
  localparam logic [15:0] B_EN = 16'h0020;
  localparam logic [15:0] B_OS = 16'h0010;

  logic        clk;
  logic        rst_n;
  logic [9:0]  addr;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic [1:0]  irq;

  int n_chk;
  int n_fail;

  dual_interval_timer u_dual_interval_timer (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [9:0] ra(input int ch, input int ofs);
    return 10'((ch + 1) * 'h80 + ofs);
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [15:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [15:0] v);
    addr = a;
    #0.2;
    v = rd_data;
  endtask

  task automatic adv(input int k);
    if (k > 0) begin
      repeat (k) @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic expect_rd(input string tag, input logic [9:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  initial begin
    #(5.0 * 190000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v1;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    adv(4);

    // R1: reset values
    for (int ch = 0; ch < 2; ch++)
      for (int o = 0; o < 16; o += 4) expect_rd("R1 reset reg", ra(ch, o), 16'h0);
    check("R1 reset irq", {14'h0, irq}, 16'h0);

    // R2: field readback and limit readback
    wr(ra(0, 'h0), 16'hFFDF);
    expect_rd("R2 ctrl fields", ra(0, 'h0), 16'h011F);
    wr(ra(1, 'h8), 16'hBEEF);
    expect_rd("R2 limit rw", ra(1, 'h8), 16'hBEEF);
    wr(ra(0, 'h0), 16'h0000);

    // R3: divider sweep, including a clipped code
    wr(ra(0, 'h8), 16'hFFFF);
    for (int c = 0; c < 10; c++) begin
      int e;
      e = (c > 8) ? 8 : c;
      wr(ra(0, 'h0), B_EN | 16'(c));
      adv(300);
      expect_rd("R3 count after 300", ra(0, 'hC), 16'(300 >> e));
      wr(ra(0, 'h0), 16'(c));
    end

    // R9: count holds while disabled
    rd(ra(0, 'hC), v1);
    adv(50);
    expect_rd("R9 idle hold", ra(0, 'hC), v1);

    // R4: rewriting enable while running does not restart
    wr(ra(0, 'h0), B_EN);
    adv(10);
    wr(ra(0, 'h0), B_EN);
    adv(5);
    expect_rd("R4 no restart", ra(0, 'hC), 16'd16);
    wr(ra(0, 'h0), 16'h0);

    // R5/R7/R8/R9: terminal edge over a grid of limits and codes
    for (int c = 0; c < 3; c++) begin
      for (int li = 0; li < 4; li++) begin
        int lim, k;
        lim = (li == 3) ? 5 : li;
        k = (lim + 1) << c;
        wr(ra(0, 'h8), 16'(lim));
        wr(ra(0, 'h0), B_IE | B_EN | 16'(c));
        adv(k - 1);
        expect_rd("R5 flag before terminal", ra(0, 'h4), 16'h0);
        check("R8 irq before terminal", {15'h0, irq[0]}, 16'h0);
        adv(1);
        expect_rd("R5 flag at terminal", ra(0, 'h4), 16'h1);
        expect_rd("R5 wrap to zero", ra(0, 'hC), 16'h0);
        check("R8 irq at terminal", {15'h0, irq[0]}, 16'h1);
        wr(ra(0, 'h0), B_IE | 16'(c));
        expect_rd("R9 pending kept", ra(0, 'h4), 16'h1);
        wr(ra(0, 'h4), 16'h0000);
        expect_rd("R7 write zero", ra(0, 'h4), 16'h1);
        wr(ra(0, 'h4), 16'h0001);
        expect_rd("R7 write one", ra(0, 'h4), 16'h0);
        check("R8 irq cleared", {15'h0, irq[0]}, 16'h0);
      end
    end

    // R5: full free-running wrap
    wr(ra(0, 'h8), 16'hFFFF);
    wr(ra(0, 'h0), B_EN);
    adv(65546);
    expect_rd("R5 free wrap count", ra(0, 'hC), 16'd10);
    expect_rd("R5 free wrap flag", ra(0, 'h4), 16'h1);
    wr(ra(0, 'h0), 16'h0);
    wr(ra(0, 'h4), 16'h1);

    // R6: one-shot stop and hold, interrupt masked (R8)
    wr(ra(0, 'h8), 16'd3);
    wr(ra(0, 'h0), B_EN | B_OS | 16'd2);
    adv(15);
    expect_rd("R6 running before terminal", ra(0, 'h0), B_EN | B_OS | 16'd2);
    adv(1);
    expect_rd("R6 enable cleared", ra(0, 'h0), B_OS | 16'd2);
    expect_rd("R6 flag set", ra(0, 'h4), 16'h1);
    check("R8 masked irq", {15'h0, irq[0]}, 16'h0);
    adv(20);
    expect_rd("R6 count holds limit", ra(0, 'hC), 16'd3);
    wr(ra(0, 'h0), B_IE | B_OS | 16'd2);
    check("R8 irq on enable", {15'h0, irq[0]}, 16'h1);
    wr(ra(0, 'h4), 16'h1);
    wr(ra(0, 'h0), 16'h0);

    // R10: channels independent with staggered start
    wr(ra(0, 'h8), 16'hFFFF);
    wr(ra(1, 'h8), 16'hFFFF);
    wr(ra(0, 'h0), B_EN | 16'd3);
    wr(ra(1, 'h0), B_EN | 16'd1);
    adv(100);
    expect_rd("R10 ch1 count", ra(1, 'hC), 16'd50);
    expect_rd("R10 ch0 count", ra(0, 'hC), 16'd12);
    wr(ra(0, 'h0), 16'h0);
    wr(ra(1, 'h0), 16'h0);

    // R11: unmapped space and count writes
    wr(ra(0, 'h8), 16'h1234);
    wr(ra(1, 'h8), 16'hABCD);
    rd(ra(0, 'hC), v1);
    expect_rd("R11 unmapped bank0", 10'h000, 16'h0);
    expect_rd("R11 unmapped hole", 10'h082, 16'h0);
    expect_rd("R11 unmapped gap", 10'h110, 16'h0);
    expect_rd("R11 unmapped bank3", 10'h180, 16'h0);
    wr(10'h000, 16'hFFFF);
    wr(10'h180, 16'hFFFF);
    wr(10'h08A, 16'hFFFF);
    wr(10'h104, 16'h0000);
    wr(ra(0, 'hC), 16'h5555);
    expect_rd("R11 ch0 limit intact", ra(0, 'h8), 16'h1234);
    expect_rd("R11 ch1 limit intact", ra(1, 'h8), 16'hABCD);
    expect_rd("R11 ch0 ctrl intact", ra(0, 'h0), 16'h0);
    expect_rd("R11 count write ignored", ra(0, 'hC), v1);
    check("R11 irq quiet", {14'h0, irq}, 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule